// File: doc/BRIEF.md
# Two-Port Channel Routing and Port Control Register

This block sits in a host controller that serves two serial storage ports. It holds a byte-wide control and status register that turns each port's power on or off and shows whether a device has been found on it. It also holds a 3-bit routing code that decides which physical port feeds the logical primary channel and which feeds the logical secondary channel. A simple single-cycle register bus reaches both registers.

Raw device-detect lines come in from each port. They pass through a two-flop synchronizer, and are then masked by that port's enable, so a port that is switched off never reports a device. The routing code drives a two-way crossbar. In the upstream direction, the crossbar carries each port's handshake bundle to the logical channel the port is assigned to. In the downstream direction, it returns each logical channel's bundle to the matching port. A code that is not supported falls back to the straight routing and raises an error flag.

Top module: `chanmap_ctrl`

## Requirements
- R1: After reset, both enables, both presence bits, the routing code and the read data are all zero, and the crossbar routes straight.
- R2: The status byte sits at offset 0x92. Bit 0 is the port 0 enable and bit 1 is the port 1 enable. Both read back what was last written, and `port_pwr_en[i]` mirrors enable bit i.
- R3: Bits 7:6 and 3:2 of the status byte always read as zero. Bits 7:2 of a write to 0x92 have no effect.
- R4: Presence bit 4 (port 0) and bit 5 (port 1) read as zero in any cycle where the port's enable is zero, including the read issued right after a write that disables the port.
- R5: While a port is enabled, its presence bit follows `det_raw` through two flops. A change set up before clock edge k shows in a read captured at edge k+2, but not in a read captured at edge k or k+1.
- R6: With routing code 000, logical channel 0 (primary, `log_up[3:0]`) carries port 0, and logical channel 1 (secondary) carries port 1. `phy_dn` returns `log_dn` to the same ports. `route_swap` and `map_err` are both 0.
- R7: With routing code 001, the primary channel carries port 1 and the secondary channel carries port 0, in both directions. `route_swap` is 1 and `map_err` is 0.
- R8: With routing codes 010 through 111, the routing is the same as with 000 and `map_err` is 1.
- R9: The routing code is bits 2:0 at offset 0x90. A read returns the code with bits 7:3 as zero, and bits 7:3 of a write are ignored. The code changes only on a write, and the crossbar follows it from the clock edge that captures the write, not before.
- R10: A read captures its data at the edge where `bus_rd` is sampled. Offsets other than 0x90 and 0x92 read as zero and are not written. `bus_rdata` holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| det_raw | input | 2 | Asynchronous device-detect line per port |
| port_pwr_en | output | 2 | Per-port power-on enable |
| phy_up | input | 2*HS_W | Handshake bundle from each port, port i at bits i*HS_W |
| log_up | output | 2*HS_W | Bundle to logical channels, primary at the low slice |
| log_dn | input | 2*HS_W | Bundle from logical channels, primary at the low slice |
| phy_dn | output | 2*HS_W | Bundle to each port, port i at bits i*HS_W |
| route_swap | output | 1 | High while the crossed routing is in force |
| map_err | output | 1 | High while an unsupported routing code is held |

## Verification
Every combination of the two enable bits is crossed with every combination of the two detect lines. This separates masking by the enable from plain detection, and catches crossed port bits. Each of the eight routing codes is applied with several asymmetric bundle patterns in both directions. These tell the straight, crossed and fallback routings apart and catch a swapped slice. Reads placed at successive edges after a detect change pin the two-flop delay exactly. A write of all ones and accesses to an unmapped offset show that the reserved bits and stray offsets have no effect.

// File: rtl/chanmap_pkg.sv
package chanmap_pkg;
  localparam int NPORT = 2;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MAP_W = 3;
  localparam logic [AW-1:0] STAT_OFS = 8'h92;
  localparam logic [AW-1:0] MAP_OFS = 8'h90;
  localparam int EN_LSB = 0;
  localparam int PRES_LSB = 4;
  localparam logic [MAP_W-1:0] MAP_STRAIGHT = 3'b000;
  localparam logic [MAP_W-1:0] MAP_CROSSED = 3'b001;
endpackage

// File: rtl/chanmap_det_sync.sv
module chanmap_det_sync #(
  parameter int N = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = raw_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chk
      // R5: a rising synchronized detect was high at the input STAGES edges earlier
      a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o[i]) |-> $past(raw_i[i], STAGES));
    end
  endgenerate
endmodule

// File: rtl/chanmap_regs.sv
module chanmap_regs
  import chanmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPORT-1:0] det_sync,
  output logic [NPORT-1:0] en_o,
  output logic [MAP_W-1:0] map_o
);
  logic [NPORT-1:0] en_q, en_d;
  logic [MAP_W-1:0] map_q, map_d;
  logic [DW-1:0]    rdata_q, rd_val, stat_view;
  logic [NPORT-1:0] pres;
  logic             stat_wr, map_wr;
  logic [DW-1-MAP_W:0] unused_wdata;

  assign unused_wdata = bus_wdata[DW-1:MAP_W];

  always_comb begin
    pres = det_sync & en_q;
    stat_view = '0;
    stat_view[EN_LSB +: NPORT] = en_q;
    stat_view[PRES_LSB +: NPORT] = pres;
  end

  always_comb begin
    stat_wr = bus_wr && (bus_addr == STAT_OFS);
    map_wr  = bus_wr && (bus_addr == MAP_OFS);
    en_d    = bus_wdata[EN_LSB +: NPORT];
    map_d   = bus_wdata[MAP_W-1:0];
    rd_val  = '0;
    if (bus_addr == STAT_OFS) rd_val = stat_view;
    else if (bus_addr == MAP_OFS) rd_val[MAP_W-1:0] = map_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      map_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (stat_wr) en_q <= en_d;
      if (map_wr)  map_q <= map_d;
      if (bus_rd)  rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign en_o = en_q;
  assign map_o = map_q;

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == STAT_OFS) |-> (bus_rdata[7:6] == 2'b00 && bus_rdata[3:2] == 2'b00));

  a_r2_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> $stable(en_q));

  a_r9_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(map_wr) |-> $stable(map_q));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

  genvar i;
  generate
    for (i = 0; i < NPORT; i++) begin : g_pres_chk
      // R4: a read of a disabled port never shows it present
      a_r4_pres_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == STAT_OFS && !en_q[i]) |-> !bus_rdata[PRES_LSB+i]);
    end
  endgenerate
endmodule

// File: rtl/chanmap_xbar.sv
module chanmap_xbar
  import chanmap_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [MAP_W-1:0]   map_code,
  input  logic [NPORT*W-1:0] phy_up,
  output logic [NPORT*W-1:0] log_up,
  input  logic [NPORT*W-1:0] log_dn,
  output logic [NPORT*W-1:0] phy_dn,
  output logic               swap_o,
  output logic               err_o
);
  always_comb begin
    swap_o = (map_code == MAP_CROSSED);
    err_o  = !((map_code == MAP_STRAIGHT) || (map_code == MAP_CROSSED));
  end

  genvar c;
  generate
    for (c = 0; c < NPORT; c++) begin : g_lane
      assign log_up[c*W +: W] = swap_o ? phy_up[(NPORT-1-c)*W +: W] : phy_up[c*W +: W];
      assign phy_dn[c*W +: W] = swap_o ? log_dn[(NPORT-1-c)*W +: W] : log_dn[c*W +: W];
    end
  endgenerate

  always_comb begin
    if (err_o) begin
      a_r8_fallback: assert (!swap_o && log_up == phy_up && phy_dn == log_dn);
    end
    if (swap_o) begin
      a_r7_crossed: assert (log_up == {phy_up[W-1:0], phy_up[2*W-1:W]} &&
                            phy_dn == {log_dn[W-1:0], log_dn[2*W-1:W]});
    end
  end
endmodule

// File: rtl/chanmap_ctrl.sv
module chanmap_ctrl
  import chanmap_pkg::*;
#(
  parameter int HS_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [1:0]            det_raw,
  output logic [1:0]            port_pwr_en,
  input  logic [2*HS_W-1:0]     phy_up,
  output logic [2*HS_W-1:0]     log_up,
  input  logic [2*HS_W-1:0]     log_dn,
  output logic [2*HS_W-1:0]     phy_dn,
  output logic                  route_swap,
  output logic                  map_err
);
  logic [1:0]       rst_pipe_q, rst_pipe_d;
  logic             rst_ns;
  logic [NPORT-1:0] det_sync;
  logic [MAP_W-1:0] map_code;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_ns = rst_pipe_q[1];

  chanmap_det_sync #(.N(NPORT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ns),
    .raw_i  (det_raw),
    .sync_o (det_sync)
  );

  chanmap_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .det_sync  (det_sync),
    .en_o      (port_pwr_en),
    .map_o     (map_code)
  );

  chanmap_xbar #(.W(HS_W)) u_xbar (
    .map_code (map_code),
    .phy_up   (phy_up),
    .log_up   (log_up),
    .log_dn   (log_dn),
    .phy_dn   (phy_dn),
    .swap_o   (route_swap),
    .err_o    (map_err)
  );

  a_r2_pwr_follows_write: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(bus_wr && bus_addr == STAT_OFS) |-> (port_pwr_en == $past(bus_wdata[1:0])));
endmodule

// File: tb/chanmap_ctrl_tb_top.sv
module chanmap_ctrl_tb_top;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic [7:0]   bus_addr;
  logic         bus_wr;
  logic         bus_rd;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [1:0]   det_raw;
  logic [1:0]   port_pwr_en;
  logic [2*W-1:0] phy_up, log_up, log_dn, phy_dn;
  logic         route_swap, map_err;

  int n_chk;
  int n_fail;

  chanmap_ctrl #(.HS_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .det_raw(det_raw),
    .port_pwr_en(port_pwr_en), .phy_up(phy_up), .log_up(log_up), .log_dn(log_dn),
    .phy_dn(phy_dn), .route_swap(route_swap), .map_err(map_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v, v0, v1, v2;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    det_raw = 2'b11; phy_up = 8'h5A; log_dn = 8'hC3;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 0);
    check("R1 pwr in reset", port_pwr_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pwr after reset", port_pwr_en, 0);
    check("R1 swap after reset", route_swap, 0);
    check("R1 err after reset", map_err, 0);
    check("R1 straight up", log_up, 8'h5A);
    reg_rd(8'h92, v); check("R1 status after reset (presence masked)", v, 0);
    reg_rd(8'h90, v); check("R1 map after reset", v, 0);

    // R2 R3 R4: sweep enables against detect inputs, writing reserved bits as ones
    for (int e = 0; e < 4; e++) begin
      for (int d = 0; d < 4; d++) begin
        det_raw = d[1:0];
        reg_wr(8'h92, 8'hFC | 8'(e));
        repeat (3) @(negedge clk);
        check("R2 pwr mirrors enable", port_pwr_en, e);
        reg_rd(8'h92, v);
        check("R2 R3 R4 status view", v, {2'b00, 2'(d & e), 2'b00, 2'(e)});
      end
    end

    // R4: disabling a present port masks presence in the very next read
    det_raw = 2'b11; reg_wr(8'h92, 8'h03); repeat (3) @(negedge clk);
    reg_wr(8'h92, 8'h01);
    reg_rd(8'h92, v); check("R4 immediate mask on disable", v, 8'h11);

    // R5: two-flop delay
    det_raw = 2'b00; reg_wr(8'h92, 8'h03); repeat (4) @(negedge clk);
    det_raw = 2'b01;
    reg_rd(8'h92, v0); reg_rd(8'h92, v1); reg_rd(8'h92, v2);
    check("R5 edge k", v0, 8'h03);
    check("R5 edge k+1", v1, 8'h03);
    check("R5 edge k+2", v2, 8'h13);

    // R10: rdata holds without a read even when presence changes
    det_raw = 2'b10; repeat (4) @(negedge clk);
    check("R10 rdata holds", bus_rdata, 8'h13);
    reg_rd(8'h91, v); check("R10 unmapped read zero", v, 0);
    reg_wr(8'h91, 8'hFF);
    reg_rd(8'h92, v); check("R10 unmapped write no effect status", v, 8'h23);
    reg_rd(8'h90, v); check("R10 unmapped write no effect map", v, 0);

    // R6 R7 R8 R9: all routing codes with several bundle patterns
    for (int m = 0; m < 8; m++) begin
      bus_addr = 8'h90; bus_wdata = 8'hF8 | 8'(m); bus_wr = 1'b1;
      #1;
      if (m == 1) check("R9 no early switch", route_swap, 0);
      @(negedge clk); bus_wr = 1'b0;
      reg_rd(8'h90, v); check("R9 map readback", v, m);
      check("R7 swap flag", route_swap, (m == 1));
      check("R8 err flag", map_err, (m > 1));
      for (int p = 0; p < 4; p++) begin
        logic [7:0] up, dn, eu, ed;
        up = 8'h1E + 8'(p * 8'h37);
        dn = 8'hA4 ^ 8'(p * 8'h29);
        phy_up = up; log_dn = dn;
        eu = (m == 1) ? {up[3:0], up[7:4]} : up;
        ed = (m == 1) ? {dn[3:0], dn[7:4]} : dn;
        #1;
        if (m == 0) begin check("R6 up", log_up, eu); check("R6 dn", phy_dn, ed); end
        else if (m == 1) begin check("R7 up", log_up, eu); check("R7 dn", phy_dn, ed); end
        else begin check("R8 up", log_up, eu); check("R8 dn", phy_dn, ed); end
      end
      repeat (2) @(negedge clk);
      check("R9 code holds", route_swap, (m == 1));
    end
    summary();
  end
endmodule